// File: doc/BRIEF.md
# Serial Tape Controller Register File

This block is the host-facing register set of a simple line-serial tape controller. The host issues an I/O operation as a 3-bit pulse code qualified by a strobe, and it supplies a 12-bit accumulator value. In return the block gives a skip request and a returned accumulator value. The operations test a flag, load the command, load the data word, read status or read the data word. The command register drives the motion logic through its unit-select, reverse, go and write bits.

The drive side presents one line at a time through `line_stb`, together with one mark-track bit and one 3-bit data nibble. On every line the 6-bit mark register and the 12-bit data register shift left. Four lines make one word. A line counter, built as a four-state phase machine, raises a quad-line flag when a word is complete. If a word completes while the previous one is still unread, the timing-error flag is set and the write bit drops by itself. While writing, the top nibble of the data register is the nibble sent to tape.

Phase machine states are `PH_0`, `PH_1`, `PH_2` and `PH_3`. Each line moves the machine one state on: `PH_0` to `PH_1`, `PH_1` to `PH_2`, `PH_2` to `PH_3`, and `PH_3` back to `PH_0`. The move from `PH_3` to `PH_0` is the wrap. A host clear (pulse codes 5, 6 and 7) returns the machine to `PH_0` from any state.

Top module: `tape_ctl_regs`

## Requirements
- R1: After reset the command, data, mark, flags and phase are all zero, and no output asserts skip or new-command.
- R2: Pulse code 4 stores accumulator bits 11:8 as the command: bit 11 selects the unit, bit 10 selects reverse, bit 9 means go and bit 8 means write. It also clears the timing error, and the returned accumulator is 0 for that operation.
- R3: `new_cmd` is high during a code-4 strobe exactly when accumulator bits 11:9 differ from the stored command bits. A change in bit 8 alone, or no change at all, leaves it low.
- R4: Codes 1, 2 and 3 assert `io_skip` while the single-line flag, the timing-error flag or the quad-line flag, respectively, is set. Without `io_stb`, skip is never asserted.
- R5: Code 5 loads the data register from the accumulator. Codes 5, 6 and 7 each clear the single-line flag and the quad-line flag, and they return the phase to `PH_0`.
- R6: Code 6 returns the status word: bits 11:8 are the command, bit 7 is `unit_wlock`, bit 6 is the timing error ORed with `unit_absent`, and bits 5:0 are the mark register. Code 7 returns the data register. Codes 0 to 3, and any cycle without strobe, return the accumulator unchanged.
- R7: Each line sets the single-line flag and advances the phase. On the wrap, the quad-line flag is set if it was clear.
- R8: On a wrap while the quad-line flag is already set, the timing error is set and the command write bit is cleared, and the other command bits are kept.
- R9: Each line shifts the data register left by 3, taking `line_nib` into bits 2:0 and truncating to 12 bits. The same line shifts the mark register left by 1, taking `line_mark` into bit 0.
- R10: `wr_nib` always shows data bits 11:9, and `cmd_write` shows the stored write bit.
- R11: The mark register is zero after any cycle in which `new_cmd` was high.
- R12: When a host operation and a line arrive in the same cycle, the host operation wins for every register it writes. The line still updates the registers the host operation leaves alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_stb | input | 1 | Host I/O operation strobe |
| io_pulse | input | 3 | Host operation code |
| io_acc | input | 12 | Accumulator value from host |
| io_skip | output | 1 | Skip request for the current operation |
| io_acc_out | output | 12 | Accumulator value returned to host |
| line_stb | input | 1 | One tape line passed under the head of the selected unit |
| line_mark | input | 1 | Mark-track bit of this line |
| line_nib | input | 3 | Data nibble read on this line |
| unit_absent | input | 1 | Selected unit not present |
| unit_wlock | input | 1 | Selected unit write-locked |
| cmd_unit | output | 1 | Unit select bit |
| cmd_rev | output | 1 | Reverse direction bit |
| cmd_go | output | 1 | Motion request bit |
| cmd_write | output | 1 | Write mode bit |
| new_cmd | output | 1 | Command load changes unit, direction or motion |
| wr_nib | output | 3 | Nibble to be written on the next line |

## Verification
Skip, the returned accumulator and `new_cmd` depend only on the present inputs and the register contents, so they are due in the same cycle as the strobe. Every register effect of an operation or a line shows after the next rising edge. The bench drives inputs at the falling edge and compares all outputs 1 ns later against a behavioural model. It then advances the model once per rising edge, so each comparison sees the effects of every earlier edge and of no later one. Flag, mark and timing-error state are observed only through skip and status reads on the ports.

// File: rtl/tape_ctl_pkg.sv
package tape_ctl_pkg;

    typedef enum logic [2:0] {
        IO_NOP       = 3'd0,
        IO_SKIP_LINE = 3'd1,
        IO_SKIP_TERR = 3'd2,
        IO_SKIP_QUAD = 3'd3,
        IO_LOAD_CMD  = 3'd4,
        IO_LOAD_DATA = 3'd5,
        IO_READ_STAT = 3'd6,
        IO_READ_DATA = 3'd7
    } io_op_e;

    // one state per line of a four-line word
    typedef enum logic [1:0] {
        PH_0 = 2'd0,
        PH_1 = 2'd1,
        PH_2 = 2'd2,
        PH_3 = 2'd3
    } phase_e;

    // bit positions inside the stored command field
    localparam int CMD_WRITE_BIT = 0;
    localparam int CMD_GO_BIT    = 1;
    localparam int CMD_REV_BIT   = 2;
    localparam int CMD_UNIT_BIT  = 3;

endpackage

// File: rtl/tape_io_decode.sv
module tape_io_decode
    import tape_ctl_pkg::*;
#(
    parameter int WORD_W = 12,
    parameter int MARK_W = 6
) (
    input  logic                       io_stb,
    input  logic [2:0]                 io_pulse,
    input  logic [WORD_W-1:0]          io_acc,
    input  logic [WORD_W-MARK_W-3:0]   cmd_q,
    input  logic                       slf,
    input  logic                       qlf,
    input  logic                       tme,
    input  logic [MARK_W-1:0]          mark_q,
    input  logic [WORD_W-1:0]          data_q,
    input  logic                       unit_absent,
    input  logic                       unit_wlock,
    output logic                       io_skip,
    output logic [WORD_W-1:0]          io_acc_out,
    output logic                       ld_cmd,
    output logic                       ld_data,
    output logic                       clr_line,
    output logic                       new_cmd
);
    localparam int CMD_W = WORD_W - MARK_W - 2;
    localparam logic [CMD_W-1:0] MOTION_MASK = ~(CMD_W'(1) << CMD_WRITE_BIT);

    io_op_e            op;
    logic [WORD_W-1:0] status;
    logic [CMD_W-1:0]  acc_cmd;

    assign op      = io_op_e'(io_pulse);
    assign acc_cmd = io_acc[WORD_W-1 -: CMD_W];
    assign status  = {cmd_q, unit_wlock, tme | unit_absent, mark_q};

    always_comb begin
        io_skip    = 1'b0;
        io_acc_out = io_acc;
        ld_cmd     = 1'b0;
        ld_data    = 1'b0;
        clr_line   = 1'b0;
        if (io_stb) begin
            unique case (op)
                IO_NOP:       ;
                IO_SKIP_LINE: io_skip = slf;
                IO_SKIP_TERR: io_skip = tme;
                IO_SKIP_QUAD: io_skip = qlf;
                IO_LOAD_CMD: begin
                    ld_cmd     = 1'b1;
                    io_acc_out = '0;
                end
                IO_LOAD_DATA: begin
                    ld_data  = 1'b1;
                    clr_line = 1'b1;
                end
                IO_READ_STAT: begin
                    clr_line   = 1'b1;
                    io_acc_out = status;
                end
                IO_READ_DATA: begin
                    clr_line   = 1'b1;
                    io_acc_out = data_q;
                end
            endcase
        end
    end

    assign new_cmd = ld_cmd && (|((cmd_q ^ acc_cmd) & MOTION_MASK));

endmodule

// File: rtl/tape_line_seq.sv
module tape_line_seq
    import tape_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_ev,
    input  logic clr_line,
    input  logic clr_terr,
    output logic slf,
    output logic qlf,
    output logic tme,
    output logic overrun
);
    phase_e phase, phase_nx;
    logic   wrap;

    always_comb begin
        unique case (phase)
            PH_0: phase_nx = PH_1;
            PH_1: phase_nx = PH_2;
            PH_2: phase_nx = PH_3;
            PH_3: phase_nx = PH_0;
        endcase
    end

    assign wrap    = line_ev && (phase == PH_3);
    assign overrun = wrap && qlf;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)        phase <= PH_0;
        else if (clr_line) phase <= PH_0;
        else if (line_ev)  phase <= phase_nx;
    end

    // flag outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slf <= 1'b0;
            qlf <= 1'b0;
            tme <= 1'b0;
        end else begin
            if (clr_line) begin
                slf <= 1'b0;
                qlf <= 1'b0;
            end else begin
                if (line_ev) slf <= 1'b1;
                if (wrap)    qlf <= 1'b1;
            end
            if (clr_terr)     tme <= 1'b0;
            else if (overrun) tme <= 1'b1;
        end
    end

endmodule

// File: rtl/tape_shift_regs.sv
module tape_shift_regs #(
    parameter int WORD_W = 12,
    parameter int NIB_W  = 3,
    parameter int MARK_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_data,
    input  logic [WORD_W-1:0] load_val,
    input  logic              line_ev,
    input  logic [NIB_W-1:0]  nib_in,
    input  logic              mark_in,
    input  logic              mark_clr,
    output logic [WORD_W-1:0] data_q,
    output logic [MARK_W-1:0] mark_q
);
    always_ff @(posedge clk) begin
        if (!rst_n)        data_q <= '0;
        else if (ld_data)  data_q <= load_val;
        else if (line_ev)  data_q <= {data_q[WORD_W-NIB_W-1:0], nib_in};
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        mark_q <= '0;
        else if (mark_clr) mark_q <= '0;
        else if (line_ev)  mark_q <= {mark_q[MARK_W-2:0], mark_in};
    end

endmodule

// File: rtl/tape_ctl_regs.sv
module tape_ctl_regs
    import tape_ctl_pkg::*;
#(
    parameter int WORD_W = 12,
    parameter int NIB_W  = 3,
    parameter int MARK_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_stb,
    input  logic [2:0]        io_pulse,
    input  logic [WORD_W-1:0] io_acc,
    output logic              io_skip,
    output logic [WORD_W-1:0] io_acc_out,
    input  logic              line_stb,
    input  logic              line_mark,
    input  logic [NIB_W-1:0]  line_nib,
    input  logic              unit_absent,
    input  logic              unit_wlock,
    output logic              cmd_unit,
    output logic              cmd_rev,
    output logic              cmd_go,
    output logic              cmd_write,
    output logic              new_cmd,
    output logic [NIB_W-1:0]  wr_nib
);
    localparam int CMD_W = WORD_W - MARK_W - 2;

    logic [CMD_W-1:0]  cmd_q;
    logic [WORD_W-1:0] data_q;
    logic [MARK_W-1:0] mark_q;
    logic              slf, qlf, tme, overrun;
    logic              ld_cmd, ld_data, clr_line;

    tape_io_decode #(.WORD_W(WORD_W), .MARK_W(MARK_W)) u_dec (
        .io_stb      (io_stb),
        .io_pulse    (io_pulse),
        .io_acc      (io_acc),
        .cmd_q       (cmd_q),
        .slf         (slf),
        .qlf         (qlf),
        .tme         (tme),
        .mark_q      (mark_q),
        .data_q      (data_q),
        .unit_absent (unit_absent),
        .unit_wlock  (unit_wlock),
        .io_skip     (io_skip),
        .io_acc_out  (io_acc_out),
        .ld_cmd      (ld_cmd),
        .ld_data     (ld_data),
        .clr_line    (clr_line),
        .new_cmd     (new_cmd)
    );

    tape_line_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_ev  (line_stb),
        .clr_line (clr_line),
        .clr_terr (ld_cmd),
        .slf      (slf),
        .qlf      (qlf),
        .tme      (tme),
        .overrun  (overrun)
    );

    tape_shift_regs #(.WORD_W(WORD_W), .NIB_W(NIB_W), .MARK_W(MARK_W)) u_shf (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_data  (ld_data),
        .load_val (io_acc),
        .line_ev  (line_stb),
        .nib_in   (line_nib),
        .mark_in  (line_mark),
        .mark_clr (new_cmd),
        .data_q   (data_q),
        .mark_q   (mark_q)
    );

    // command register: a host load outranks the overrun write drop
    always_ff @(posedge clk) begin
        if (!rst_n)       cmd_q <= '0;
        else if (ld_cmd)  cmd_q <= io_acc[WORD_W-1 -: CMD_W];
        else if (overrun) cmd_q[CMD_WRITE_BIT] <= 1'b0;
    end

    assign cmd_unit  = cmd_q[CMD_UNIT_BIT];
    assign cmd_rev   = cmd_q[CMD_REV_BIT];
    assign cmd_go    = cmd_q[CMD_GO_BIT];
    assign cmd_write = cmd_q[CMD_WRITE_BIT];
    assign wr_nib    = data_q[WORD_W-1 -: NIB_W];

endmodule

// File: rtl/tape_ctl_regs_chk.sv
module tape_ctl_regs_chk #(
    parameter int WORD_W = 12,
    parameter int NIB_W  = 3,
    parameter int MARK_W = 6
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     io_stb,
    input logic [2:0]               io_pulse,
    input logic [WORD_W-1:0]        io_acc,
    input logic                     io_skip,
    input logic                     line_stb,
    input logic [NIB_W-1:0]         line_nib,
    input logic                     new_cmd,
    input logic                     cmd_write,
    input logic                     slf,
    input logic                     tme,
    input logic [MARK_W-1:0]        mark_q,
    input logic [WORD_W-1:0]        data_q,
    input logic [WORD_W-MARK_W-3:0] cmd_q
);
    localparam int CMD_W = WORD_W - MARK_W - 2;

    a_r2_cmd_load: assert property (@(posedge clk) disable iff (!rst_n)
        (io_stb && io_pulse == 3'd4) |=> (cmd_q == $past(io_acc[WORD_W-1 -: CMD_W])) && !tme);

    a_r4_no_skip_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !io_stb |-> !io_skip);

    a_r5_clear_single: assert property (@(posedge clk) disable iff (!rst_n)
        (io_stb && io_pulse >= 3'd5) |=> !slf);

    a_r7_line_sets_single: assert property (@(posedge clk) disable iff (!rst_n)
        (line_stb && !(io_stb && io_pulse >= 3'd5)) |=> slf);

    a_r8_overrun_drops_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tme) |-> !cmd_write);

    a_r9_data_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (line_stb && !(io_stb && io_pulse == 3'd5)) |=>
            (data_q[WORD_W-1:NIB_W] == $past(data_q[WORD_W-NIB_W-1:0])) &&
            (data_q[NIB_W-1:0] == $past(line_nib)));

    a_r11_mark_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        new_cmd |=> (mark_q == '0));

endmodule

bind tape_ctl_regs tape_ctl_regs_chk #(.WORD_W(WORD_W), .NIB_W(NIB_W), .MARK_W(MARK_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_stb    (io_stb),
    .io_pulse  (io_pulse),
    .io_acc    (io_acc),
    .io_skip   (io_skip),
    .line_stb  (line_stb),
    .line_nib  (line_nib),
    .new_cmd   (new_cmd),
    .cmd_write (cmd_write),
    .slf       (slf),
    .tme       (tme),
    .mark_q    (mark_q),
    .data_q    (data_q),
    .cmd_q     (cmd_q)
);

// File: tb/tape_ctl_regs_tb.sv
`timescale 1ns/1ps
module tape_ctl_regs_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_stb = 1'b0;
    logic [2:0]  io_pulse = 3'd0;
    logic [11:0] io_acc = 12'd0;
    logic        io_skip;
    logic [11:0] io_acc_out;
    logic        line_stb = 1'b0;
    logic        line_mark = 1'b0;
    logic [2:0]  line_nib = 3'd0;
    logic        unit_absent = 1'b0;
    logic        unit_wlock = 1'b0;
    logic        cmd_unit, cmd_rev, cmd_go, cmd_write, new_cmd;
    logic [2:0]  wr_nib;

    int n_cmp = 0;
    int n_bad = 0;

    // behavioural reference state
    int m_cmd = 0, m_dat = 0, m_mtk = 0, m_slf = 0, m_qlf = 0, m_cnt = 0, m_tme = 0;

    always #4 clk = ~clk;

    tape_ctl_regs u_dut (
        .clk(clk), .rst_n(rst_n), .io_stb(io_stb), .io_pulse(io_pulse), .io_acc(io_acc),
        .io_skip(io_skip), .io_acc_out(io_acc_out), .line_stb(line_stb), .line_mark(line_mark),
        .line_nib(line_nib), .unit_absent(unit_absent), .unit_wlock(unit_wlock),
        .cmd_unit(cmd_unit), .cmd_rev(cmd_rev), .cmd_go(cmd_go), .cmd_write(cmd_write),
        .new_cmd(new_cmd), .wr_nib(wr_nib)
    );

    task automatic cmp(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0o expected %0o", req, what, act, exp);
        end
    endtask

    task automatic step(input bit stb, input int p, input int a,
                        input bit ln, input bit mb, input int nb, input string req);
        int e_skip, e_acc, e_new, stat, c;
        @(negedge clk);
        io_stb = stb; io_pulse = 3'(p); io_acc = 12'(a);
        line_stb = ln; line_mark = mb; line_nib = 3'(nb);
        #1;
        stat   = (m_cmd << 8) | (int'(unit_wlock) << 7) | ((m_tme | int'(unit_absent)) << 6) | m_mtk;
        e_skip = stb && ((p == 1 && m_slf != 0) || (p == 2 && m_tme != 0) || (p == 3 && m_qlf != 0));
        e_acc  = a;
        if (stb && p == 4) e_acc = 0;
        if (stb && p == 6) e_acc = stat;
        if (stb && p == 7) e_acc = m_dat;
        e_new  = (stb && p == 4 && (((m_cmd ^ (a >> 8)) & 14) != 0)) ? 1 : 0;
        cmp(req, "skip", int'(io_skip), e_skip);
        cmp(req, "acc_out", int'(io_acc_out), e_acc);
        cmp(req, "new_cmd", int'(new_cmd), e_new);
        cmp(req, "command", int'({cmd_unit, cmd_rev, cmd_go, cmd_write}), m_cmd);
        cmp(req, "wr_nib", int'(wr_nib), (m_dat >> 9) & 7);
        // advance the model by one rising edge: line first, host second
        c = m_cmd;
        if (ln) begin
            m_dat = ((m_dat << 3) | nb) & 'hfff;
            m_mtk = ((m_mtk << 1) | int'(mb)) & 'h3f;
            m_cnt = (m_cnt + 1) % 4;
            if (m_cnt == 0) begin
                if (m_qlf != 0) begin
                    m_tme = 1;
                    m_cmd = m_cmd & 'he;
                end
                m_qlf = 1;
            end
            m_slf = 1;
        end
        if (stb) begin
            if (p == 4) begin
                m_tme = 0;
                m_cmd = (a >> 8) & 'hf;
                if (e_new != 0) m_mtk = 0;
            end
            if (p == 5) m_dat = a & 'hfff;
            if (p >= 5) begin
                m_slf = 0; m_qlf = 0; m_cnt = 0;
            end
        end
        if (c < 0) m_cmd = 0;
    endtask

    task automatic lines(input int n, input int nb, input string req);
        for (int i = 0; i < n; i++) step(0, 0, 0, 1, i[0], (nb + i) & 7, req);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        step(0, 0, 'o1234, 0, 0, 0, "R1");
        step(1, 6, 'o7777, 0, 0, 0, "R1");
        step(1, 1, 0, 0, 0, 0, "R1");
        // R2 command load, go forward
        step(1, 4, 'o1000, 0, 0, 0, "R2");
        // R9 shifting, R4 skips mid-word
        step(0, 0, 0, 1, 1, 5, "R9");
        step(0, 0, 0, 1, 0, 3, "R9");
        step(0, 0, 0, 1, 1, 7, "R9");
        step(1, 1, 'o55, 0, 0, 0, "R4");
        step(1, 3, 'o55, 0, 0, 0, "R4");
        step(0, 0, 0, 1, 1, 1, "R7");
        step(1, 3, 0, 0, 0, 0, "R7");
        step(1, 6, 0, 0, 0, 0, "R6");
        step(1, 1, 0, 0, 0, 0, "R5");
        step(1, 7, 0, 0, 0, 0, "R9");
        step(1, 3, 0, 0, 0, 0, "R5");
        // R10 write nibble presentation after a data load
        step(1, 5, 'o6425, 0, 0, 0, "R5");
        step(1, 4, 'o1400, 0, 0, 0, "R3");
        step(1, 6, 0, 0, 0, 0, "R11");
        lines(4, 0, "R10");
        // R8 overrun with unread word
        lines(4, 2, "R8");
        step(1, 2, 0, 0, 0, 0, "R8");
        step(1, 6, 0, 0, 0, 0, "R8");
        // R3 direction change, R2 timing error cleared
        step(1, 4, 'o3000, 0, 0, 0, "R3");
        step(1, 2, 0, 0, 0, 0, "R2");
        step(1, 6, 0, 0, 0, 0, "R11");
        step(1, 4, 'o3000, 0, 0, 0, "R3");
        // R6 absent and write-locked status
        unit_absent = 1'b1; unit_wlock = 1'b1;
        step(1, 6, 0, 0, 0, 0, "R6");
        unit_absent = 1'b0; unit_wlock = 1'b0;
        step(1, 0, 'o4321, 0, 0, 0, "R6");
        // R12 same-cycle host operation and line
        lines(3, 4, "R12");
        step(1, 5, 'o7070, 1, 1, 6, "R12");
        step(1, 7, 0, 0, 0, 0, "R12");
        step(1, 4, 'o3400, 0, 0, 0, "R12");
        lines(7, 1, "R12");
        step(1, 4, 'o7400, 1, 1, 2, "R12");
        step(1, 2, 0, 0, 0, 0, "R12");
        step(1, 6, 0, 1, 1, 3, "R12");
        // mixed pseudo-random traffic
        begin
            logic [15:0] lf = 16'hACE1;
            for (int k = 0; k < 400; k++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                unit_absent = lf[11] & lf[3];
                unit_wlock  = lf[9];
                step(lf[1:0] == 2'b00, int'(lf[6:4]), int'({lf[15:12], lf[7:0]}),
                     lf[2] | lf[8], lf[10], int'(lf[14:12]), "R6");
            end
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog: actual expired expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule